// File: doc/BRIEF.md
# Bit-Serial Handshaked Word Transmitter

This block sends 16-bit words from a host processor to a remote network node one bit at a time. Every bit carries its own four-phase handshake: the transmitter presents a bit and raises its bit-valid strobe only while the receiver's ready line is high. It then holds the strobe and the bit until ready falls, and drops the strobe before it moves on. The remote end may stall for any length of time at any point in this exchange without losing data. The only data storage is one word-wide shift register.

Software drives the block with single-cycle strobes. A start strobe puts a stopped transmitter straight into its running state, where its first act is to raise a data-request wakeup. A load strobe takes a word from the bus, withdraws the wakeup and begins shifting. When the word has gone out, the wakeup returns. A last-word strobe causes one extra end-of-message marker bit after the current word. A clear strobe halts everything without restarting.

A loopback control turns the serial bit, strobe and marker away from the network pins to a local receiver, and takes the ready handshake from that receiver. The ready input is asynchronous and passes through a two-flop synchroniser.

Top module: `bitser_tx`

## Requirements
- R1: Out of reset the wakeup, both strobe outputs, both marker outputs and both data outputs are 0.
- R2: A start strobe while stopped raises the wakeup on the next clock edge. A start strobe while a word is being sent has no effect: the wakeup stays low and the word completes unchanged.
- R3: A load strobe captures the bus word and clears the wakeup on the next clock edge, and transmission begins.
- R4: Bits leave most significant first. The strobe rises only while synchronised ready is high. Strobe, bit and marker hold steady until synchronised ready is seen low.
- R5: A stall of hundreds of cycles at any handshake phase loses no bit and changes no output.
- R6: When the final bit of a word completes, the wakeup rises, unless a marker bit is owed.
- R7: A last-word strobe after a load adds one marker bit (marker output 1, data 0) after the 16 data bits. The flag then clears by itself, so the next word has no marker.
- R8: A last-word strobe that arrives in the very cycle the final data bit completes still produces the marker.
- R9: A clear strobe stops the transmitter, drops the strobe and the wakeup, and the transmitter stays stopped. A load in the same cycle as a clear is ignored.
- R10: With loopback on, bit, strobe and marker appear only on the loopback outputs, and ready comes from the loopback ready input. With loopback off, the loopback outputs stay 0 and the loopback ready input is ignored.
- R11: A change of ready takes effect on the third rising clock edge after it: two synchroniser edges and then the state change. The strobe therefore falls exactly on that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_stb | input | 1 | Load strobe for the bus word |
| wr_word | input | 16 | Word to send |
| start_stb | input | 1 | Output-start strobe |
| clr_stb | input | 1 | Output-clear strobe |
| last_stb | input | 1 | Sets the last-word flag |
| loop_en | input | 1 | Loopback select |
| net_rdy_i | input | 1 | Network receiver ready (asynchronous) |
| net_data_o | output | 1 | Network serial bit |
| net_stb_o | output | 1 | Network bit-valid strobe |
| net_last_o | output | 1 | Network end-of-message marker |
| lb_rdy_i | input | 1 | Loopback receiver ready (asynchronous) |
| lb_data_o | output | 1 | Loopback serial bit |
| lb_stb_o | output | 1 | Loopback bit-valid strobe |
| lb_last_o | output | 1 | Loopback end-of-message marker |
| wake_o | output | 1 | Data-request wakeup |

## Verification
Two pairs of functions can land on the same clock edge. In the first, the last-word strobe arrives on the edge where the final data bit's handshake completes. The bench releases ready and then raises the last-word strobe two cycles later, so the strobe meets the state change. The case is judged by the marker bit that follows and by the wakeup staying low until that marker completes. In the second, a clear and a load are issued together while a bit is on the wire. The case is judged by the strobe and wakeup staying low for many cycles while ready is held high.

// File: rtl/bstx_pkg.sv
package bstx_pkg;
  typedef enum logic [1:0] {
    ST_OFF  = 2'd0,
    ST_REQ  = 2'd1,
    ST_WAIT = 2'd2,
    ST_STB  = 2'd3
  } tx_state_e;
endpackage

// File: rtl/bstx_sync.sv
module bstx_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] pipe_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe_q <= {STAGES{RST_VAL}};
    else        pipe_q <= {pipe_q[STAGES-2:0], d};
  end

  assign q = pipe_q[STAGES-1];
endmodule

// File: rtl/bstx_shift.sv
module bstx_shift #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] din,
  input  logic         shift,
  output logic         msb
);
  logic [W-1:0] sr_q, sr_d;

  always_comb begin
    sr_d = sr_q;
    if (load)       sr_d = din;
    else if (shift) sr_d = {sr_q[W-2:0], 1'b0};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sr_q <= '0;
    else        sr_q <= sr_d;
  end

  assign msb = sr_q[W-1];
endmodule

// File: rtl/bstx_fsm.sv
module bstx_fsm
  import bstx_pkg::*;
#(
  parameter int W = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic load,
  input  logic clr,
  input  logic last_set,
  input  logic rdy_s,
  output logic shift,
  output logic marker,
  output logic stb,
  output logic wake
);
  localparam int CW = $clog2(W + 1);

  tx_state_e     st_q, st_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          mk_q, mk_d;
  logic          flag_q, flag_d;
  logic          done;

  assign done = (st_q == ST_STB) && !rdy_s;

  always_comb begin
    st_d   = st_q;
    cnt_d  = cnt_q;
    mk_d   = mk_q;
    flag_d = flag_q | last_set;
    shift  = 1'b0;
    if (clr) begin
      st_d   = ST_OFF;
      mk_d   = 1'b0;
      flag_d = 1'b0;
    end else if (load) begin
      st_d  = ST_WAIT;
      cnt_d = CW'(W);
      mk_d  = 1'b0;
    end else if (start && st_q == ST_OFF) begin
      st_d = ST_REQ;
    end else if (st_q == ST_WAIT && rdy_s) begin
      st_d = ST_STB;
    end else if (done) begin
      if (mk_q) begin
        mk_d   = 1'b0;
        flag_d = 1'b0;
        st_d   = ST_REQ;
      end else if (cnt_q > CW'(1)) begin
        cnt_d = cnt_q - CW'(1);
        shift = 1'b1;
        st_d  = ST_WAIT;
      end else if (flag_q || last_set) begin
        cnt_d = '0;
        mk_d  = 1'b1;
        st_d  = ST_WAIT;
      end else begin
        cnt_d = '0;
        st_d  = ST_REQ;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_OFF;
      cnt_q  <= '0;
      mk_q   <= 1'b0;
      flag_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      cnt_q  <= cnt_d;
      mk_q   <= mk_d;
      flag_q <= flag_d;
    end
  end

  assign marker = mk_q;
  assign stb    = (st_q == ST_STB);
  assign wake   = (st_q == ST_REQ);

  // R4
  stb_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stb && rdy_s && !clr && !load) |=> stb);

  // R3
  load_wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (load && !clr) |=> !wake);

  // R9
  clr_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (!stb && !wake));
endmodule

// File: rtl/bitser_tx.sv
module bitser_tx #(
  parameter int WORD_W      = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_stb,
  input  logic [WORD_W-1:0] wr_word,
  input  logic              start_stb,
  input  logic              clr_stb,
  input  logic              last_stb,
  input  logic              loop_en,
  input  logic              net_rdy_i,
  output logic              net_data_o,
  output logic              net_stb_o,
  output logic              net_last_o,
  input  logic              lb_rdy_i,
  output logic              lb_data_o,
  output logic              lb_stb_o,
  output logic              lb_last_o,
  output logic              wake_o
);
  logic rst_s;
  logic rdy_raw, rdy_s;
  logic load_eff, shift, marker, stb, msb;
  logic tx_data;

  bstx_sync #(.STAGES(2), .RST_VAL(1'b0)) u_rst_sync (
    .clk(clk), .rst_n(rst_n), .d(1'b1), .q(rst_s)
  );

  assign rdy_raw = loop_en ? lb_rdy_i : net_rdy_i;

  bstx_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_rdy_sync (
    .clk(clk), .rst_n(rst_s), .d(rdy_raw), .q(rdy_s)
  );

  assign load_eff = wr_stb & ~clr_stb;

  bstx_fsm #(.W(WORD_W)) u_fsm (
    .clk(clk), .rst_n(rst_s), .start(start_stb), .load(load_eff),
    .clr(clr_stb), .last_set(last_stb), .rdy_s(rdy_s),
    .shift(shift), .marker(marker), .stb(stb), .wake(wake_o)
  );

  bstx_shift #(.W(WORD_W)) u_shift (
    .clk(clk), .rst_n(rst_s), .load(load_eff), .din(wr_word),
    .shift(shift), .msb(msb)
  );

  assign tx_data = marker ? 1'b0 : msb;

  always_comb begin
    net_data_o = 1'b0;
    net_stb_o  = 1'b0;
    net_last_o = 1'b0;
    lb_data_o  = 1'b0;
    lb_stb_o   = 1'b0;
    lb_last_o  = 1'b0;
    if (loop_en) begin
      lb_data_o = tx_data;
      lb_stb_o  = stb;
      lb_last_o = marker;
    end else begin
      net_data_o = tx_data;
      net_stb_o  = stb;
      net_last_o = marker;
    end
  end

  // R4
  bit_steady_chk: assert property (@(posedge clk) disable iff (!rst_s)
    (stb && $past(stb)) |-> ($stable(tx_data) && $stable(marker)));
endmodule

// File: tb/tb_bitser_tx.sv
module tb_bitser_tx;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_stb, start_stb, clr_stb, last_stb, loop_en;
  logic [15:0] wr_word;
  logic        rdy_drv;
  logic        net_rdy_i, lb_rdy_i;
  logic        net_data_o, net_stb_o, net_last_o;
  logic        lb_data_o, lb_stb_o, lb_last_o, wake_o;

  int n_chk = 0;
  int n_bad = 0;
  bit mon_on = 1'b0;
  bit exp_wake = 1'b0;

  always #5 clk = ~clk;

  assign net_rdy_i = loop_en ? 1'b0 : rdy_drv;
  assign lb_rdy_i  = loop_en ? rdy_drv : 1'b0;

  wire cur_stb  = loop_en ? lb_stb_o  : net_stb_o;
  wire cur_data = loop_en ? lb_data_o : net_data_o;
  wire cur_last = loop_en ? lb_last_o : net_last_o;

  bitser_tx dut (
    .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .wr_word(wr_word),
    .start_stb(start_stb), .clr_stb(clr_stb), .last_stb(last_stb),
    .loop_en(loop_en), .net_rdy_i(net_rdy_i), .net_data_o(net_data_o),
    .net_stb_o(net_stb_o), .net_last_o(net_last_o), .lb_rdy_i(lb_rdy_i),
    .lb_data_o(lb_data_o), .lb_stb_o(lb_stb_o), .lb_last_o(lb_last_o),
    .wake_o(wake_o)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, expv, $time);
    end
  endtask

  // per-cycle comparison against the bench model
  always @(posedge clk) begin
    #2;
    if (mon_on) begin
      chk(wake_o == exp_wake, "R6 wakeup vs model", wake_o, exp_wake);
      if (loop_en)
        chk({net_stb_o, net_data_o, net_last_o} == 3'b000, "R10 network pins idle",
            {net_stb_o, net_data_o, net_last_o}, 0);
      else
        chk({lb_stb_o, lb_data_o, lb_last_o} == 3'b000, "R10 loopback pins idle",
            {lb_stb_o, lb_data_o, lb_last_o}, 0);
    end
  end

  // receive one bit through the handshake; dly stalls each phase
  task automatic recv_bit(input bit ed, input bit el, input bit fin, input int dly,
                          input bit lset);
    do @(negedge clk); while (!cur_stb);
    chk(cur_data == ed, "R4 bit value", cur_data, ed);
    chk(cur_last == el, "R7 marker line", cur_last, el);
    for (int k = 0; k < dly; k++) begin
      @(negedge clk);
      chk(cur_stb && cur_data == ed && cur_last == el, "R5 held during stall",
          {cur_stb, cur_data, cur_last}, {1'b1, ed, el});
    end
    rdy_drv = 1'b0;
    @(negedge clk);
    @(negedge clk);
    chk(cur_stb == 1'b1, "R11 strobe before third edge", cur_stb, 1);
    if (lset) last_stb = 1'b1;
    else if (fin) exp_wake = 1'b1;
    @(negedge clk);
    last_stb = 1'b0;
    chk(cur_stb == 1'b0, "R11 strobe falls on third edge", cur_stb, 0);
    for (int k = 0; k < dly; k++) @(negedge clk);
    rdy_drv = 1'b1;
  endtask

  task automatic recv_word(input logic [15:0] w, input int dly, input bit mk,
                           input bit lset);
    for (int i = 15; i >= 0; i--)
      recv_bit(w[i], 1'b0, (i == 0) && !mk && !lset, dly, lset && (i == 0));
    if (mk || lset) recv_bit(1'b0, 1'b1, 1'b1, dly, 1'b0);
    repeat (3) @(negedge clk);
    chk(wake_o == 1'b1, "R6 request after word", wake_o, 1);
  endtask

  task automatic load_word(input logic [15:0] w, input bit mk);
    @(negedge clk);
    wr_stb = 1'b1; wr_word = w; exp_wake = 1'b0;
    @(negedge clk);
    wr_stb = 1'b0;
    chk(wake_o == 1'b0, "R3 load clears wakeup", wake_o, 0);
    if (mk) begin
      last_stb = 1'b1;
      @(negedge clk);
      last_stb = 1'b0;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; wr_stb = 0; start_stb = 0; clr_stb = 0; last_stb = 0;
    loop_en = 0; wr_word = '0; rdy_drv = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1
    chk({wake_o, net_stb_o, net_data_o, net_last_o, lb_stb_o, lb_data_o, lb_last_o} == 7'd0,
        "R1 reset outputs", {wake_o, net_stb_o, net_data_o, net_last_o}, 0);
    mon_on = 1'b1;

    // R2 start from stopped
    start_stb = 1'b1; exp_wake = 1'b1;
    @(negedge clk);
    start_stb = 1'b0;
    chk(wake_o == 1'b1, "R2 start raises wakeup", wake_o, 1);

    // plain words, zero and small delays
    load_word(16'hA5C3, 1'b0); recv_word(16'hA5C3, 0, 1'b0, 1'b0);
    load_word(16'h8001, 1'b0); recv_word(16'h8001, 2, 1'b0, 1'b0);

    // R2 start while busy is ignored
    load_word(16'h3C5A, 1'b0);
    do @(negedge clk); while (!cur_stb);
    start_stb = 1'b1;
    @(negedge clk);
    start_stb = 1'b0;
    chk(wake_o == 1'b0, "R2 start ignored while busy", wake_o, 0);
    recv_word(16'h3C5A, 1, 1'b0, 1'b0);

    // R7 marker, then flag clears for following word
    load_word(16'hF00F, 1'b1); recv_word(16'hF00F, 1, 1'b1, 1'b0);
    load_word(16'h0FF0, 1'b0); recv_word(16'h0FF0, 0, 1'b0, 1'b0);

    // R8 last strobe coinciding with final data bit completion
    load_word(16'h1234, 1'b0); recv_word(16'h1234, 0, 1'b0, 1'b1);
    load_word(16'h4321, 1'b0); recv_word(16'h4321, 0, 1'b0, 1'b0);

    // R5 long stalls
    load_word(16'hBEEF, 1'b0); recv_word(16'hBEEF, 600, 1'b0, 1'b0);

    // R10 loopback
    @(negedge clk); loop_en = 1'b1;
    load_word(16'hC0DE, 1'b1); recv_word(16'hC0DE, 3, 1'b1, 1'b0);
    @(negedge clk); loop_en = 1'b0;
    load_word(16'h5555, 1'b0); recv_word(16'h5555, 0, 1'b0, 1'b0);

    // R9 clear together with load while a bit is on the wire
    load_word(16'hFFFF, 1'b1);
    do @(negedge clk); while (!cur_stb);
    clr_stb = 1'b1; wr_stb = 1'b1; wr_word = 16'h7777; exp_wake = 1'b0;
    @(negedge clk);
    clr_stb = 1'b0; wr_stb = 1'b0;
    for (int k = 0; k < 30; k++) begin
      chk(net_stb_o == 1'b0 && wake_o == 1'b0, "R9 stays stopped",
          {net_stb_o, wake_o}, 0);
      @(negedge clk);
    end
    // R9 last flag was cleared: new word has no marker
    load_word(16'h2468, 1'b0); recv_word(16'h2468, 0, 1'b0, 1'b0);

    mon_on = 1'b0;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule